// File: doc/BRIEF.md
# Exhaustive PLL Divider Search

This block chooses the feedback divider M, the reference-side divider N and the post-divider exponent K for a frequency synthesizer fed by a fixed 14.31818 MHz reference. A request arrives as a frequency in units of 0.01 MHz together with a one-cycle start pulse. The block walks every legal (M, N) pair, computes the frequency that pair would produce, and keeps the pair with the smallest absolute error against the request. When the search ends, it raises done for one cycle and presents the packed programming word alongside the separate M, N and K values.

The candidate frequency uses the fixed-point constant 938356, which is the reference times 65536. Both the target and the candidate are kept on a 1/256 scale, so the comparison needs only integer arithmetic. Each candidate goes through a multi-cycle iterative divider. A candidate comparison is finished before the next pair starts. A request of zero skips the search and returns a fixed word.

Top module: `pll_div_search`

## Requirements
- R1: A start with freq_i equal to 0 returns word_o = 0x00E0 with m_o, n_o and k_o all 0. done_o is high in the cycle after the edge that samples start. No search runs.
- R2: A nonzero request below 8000 gives exactly the result of a request of 8000. A request above 15938 gives exactly the result of a request of 15938.
- R3: The target is clamped_freq × 256 / 100, truncated. K is the number of doublings the clamped frequency needs to reach at least 64000. This is 3 for every clamped value.
- R4: The candidates are M = 2..30 in the outer loop and N = 35..247 in the inner loop. Each candidate frequency is floor(938356 × (N + 8) / (2^K × 256 × (M + 2))). The returned M and N always lie in these ranges.
- R5: The returned pair has the smallest |target − candidate| over all pairs. A later pair replaces the held best pair only when its error is strictly smaller, so on a tie the first pair visited wins. The starting best error is 0xFFFFFFFF.
- R6: word_o = (N << 8) + (K << 6) + M. N occupies bits 15:8, K occupies bits 7:6 and M occupies bits 5:0.
- R7: For a nonzero request, done_o is high after exactly 3 × 29 × 213 = 18531 clock edges following the edge that samples start. Each candidate takes three cycles.
- R8: After reset, all outputs are 0. done_o is a one-cycle pulse. word_o, m_o, n_o and k_o hold their value until the next completion.
- R9: A start that arrives while a search is running is ignored. It changes neither the result nor the completion time.
- R10: A start sampled in the cycle where done_o is high is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, sampled while idle |
| freq_i | input | 16 | Requested frequency in 0.01 MHz units |
| word_o | output | 16 | Packed programming word |
| m_o | output | 5 | Chosen M |
| n_o | output | 8 | Chosen N |
| k_o | output | 2 | Post-divider exponent K |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two things can happen in the same cycle: the completion of one search, which raises done_o, and the acceptance of the next request. The bench provokes this by raising start with a zero frequency exactly in the done cycle of a full search. It judges the result in three steps:
- In the done cycle, the earlier result must still be visible.
- One edge later, done_o must be high again with word 0x00E0.
- After that, done_o must fall while the new word holds.

// File: rtl/pll_search_pkg.sv
`timescale 1ns/1ps
package pll_search_pkg;
  localparam int unsigned REF_X65536   = 938356;  // 14.31818 MHz * 65536
  localparam int unsigned FREQ_LO      = 8000;
  localparam int unsigned FREQ_HI      = 15938;
  localparam int unsigned ZERO_PROG    = 32'h00E0;

  typedef enum logic {
    SRCH_IDLE,
    SRCH_RUN
  } srch_state_e;
endpackage

// File: rtl/pll_target_calc.sv
`timescale 1ns/1ps
module pll_target_calc #(
  parameter int unsigned FREQ_W = 16,
  parameter int unsigned F_MIN  = 8000,
  parameter int unsigned F_MAX  = 15938,
  parameter int unsigned K_W    = 2,
  parameter int unsigned TGT_W  = 32
) (
  input  logic [FREQ_W-1:0] freq_i,
  output logic [TGT_W-1:0]  tgt_o,
  output logic [K_W-1:0]    k_o
);
  localparam int unsigned K_MAX = (1 << K_W) - 1;
  localparam logic [31:0] FLOOR_X8 = 32'(F_MIN) << 3;

  logic [31:0] fc;

  always_comb begin
    fc = 32'(freq_i);
    if (fc < F_MIN)      fc = F_MIN;
    else if (fc > F_MAX) fc = F_MAX;
    tgt_o = TGT_W'((fc << 8) / 32'd100);
    // smallest shift reaching the floor; scan downward so the last hit wins
    k_o = K_W'(K_MAX);
    for (int j = int'(K_MAX); j >= 0; j--) begin
      if ((fc << j) >= FLOOR_X8) k_o = K_W'(j);
    end
  end

  always_comb begin
    assert_k_floor_R3: assert (((32'(tgt_o) * 32'd100) >> 8) <= fc);
  end
endmodule

// File: rtl/pll_quot_div.sv
`timescale 1ns/1ps
module pll_quot_div #(
  parameter int unsigned DVD_W     = 20,
  parameter int unsigned DVS_W     = 6,
  parameter int unsigned STEP_BITS = 10  // DVD_W must be a multiple
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic [DVD_W-1:0] quot_o,
  output logic             valid_o
);
  localparam int unsigned CYC   = DVD_W / STEP_BITS;
  localparam int unsigned CNT_W = $clog2(CYC + 1);

  logic [DVS_W:0]   rem_q, rem_d;
  logic [DVD_W-1:0] dq_q, dq_d, dvd_q;
  logic [DVS_W-1:0] dvs_q;
  logic [CNT_W-1:0] cnt_q;

  // STEP_BITS restoring stages per cycle; dq shifts dividend out, quotient in
  always_comb begin
    rem_d = rem_q;
    dq_d  = dq_q;
    for (int s = 0; s < int'(STEP_BITS); s++) begin
      rem_d = {rem_d[DVS_W-1:0], dq_d[DVD_W-1]};
      dq_d  = {dq_d[DVD_W-2:0], 1'b0};
      if (rem_d >= {1'b0, dvs_q}) begin
        rem_d    = rem_d - {1'b0, dvs_q};
        dq_d[0]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      dq_q    <= '0;
      dvd_q   <= '0;
      dvs_q   <= '0;
      cnt_q   <= '0;
      valid_o <= 1'b0;
    end else if (load_i) begin
      rem_q   <= '0;
      dq_q    <= dividend_i;
      dvd_q   <= dividend_i;
      dvs_q   <= divisor_i;
      cnt_q   <= CNT_W'(CYC);
      valid_o <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q   <= rem_d;
      dq_q    <= dq_d;
      cnt_q   <= cnt_q - CNT_W'(1);
      valid_o <= (cnt_q == CNT_W'(1));
    end else begin
      valid_o <= 1'b0;
    end
  end

  assign quot_o = dq_q;

  assert_quot_exact_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((32'(quot_o) * 32'(dvs_q) <= 32'(dvd_q)) &&
                 (32'(dvd_q) - 32'(quot_o) * 32'(dvs_q) < 32'(dvs_q))));

  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/pll_div_search.sv
`timescale 1ns/1ps
module pll_div_search import pll_search_pkg::*; #(
  parameter int unsigned FREQ_W    = 16,
  parameter int unsigned F_MIN     = FREQ_LO,
  parameter int unsigned F_MAX     = FREQ_HI,
  parameter int unsigned M_MIN     = 2,
  parameter int unsigned M_MAX     = 30,
  parameter int unsigned N_MIN     = 35,
  parameter int unsigned N_MAX     = 247,
  parameter int unsigned M_W       = 5,
  parameter int unsigned N_W       = 8,
  parameter int unsigned K_W       = 2,
  parameter int unsigned REF_X256  = REF_X65536,
  parameter int unsigned ZERO_WORD = ZERO_PROG,
  parameter int unsigned DVD_W     = 20,
  parameter int unsigned STEP_BITS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic [N_W+7:0]    word_o,
  output logic [M_W-1:0]    m_o,
  output logic [N_W-1:0]    n_o,
  output logic [K_W-1:0]    k_o,
  output logic              done_o
);
  localparam int unsigned WORD_W = N_W + 8;
  localparam int unsigned DVS_W  = $clog2(M_MAX + 3);

  srch_state_e      st_q;
  logic [31:0]      tgt_c, tgt_q, best_err_q, err_c, prod_c;
  logic [K_W-1:0]   k_c, k_q, ld_k;
  logic [M_W-1:0]   cur_m_q, best_m_q, nxt_m, ld_m, fin_m;
  logic [N_W-1:0]   cur_n_q, best_n_q, nxt_n, ld_n, fin_n;
  logic [DVD_W-1:0] dvd_c, div_q;
  logic [DVS_W-1:0] dvs_c;
  logic             div_load, div_valid, better_c, last_c, zero_req, go_req;

  pll_target_calc #(
    .FREQ_W(FREQ_W), .F_MIN(F_MIN), .F_MAX(F_MAX), .K_W(K_W), .TGT_W(32)
  ) u_tgt (
    .freq_i(freq_i), .tgt_o(tgt_c), .k_o(k_c)
  );

  function automatic logic [WORD_W-1:0] pack_word(logic [N_W-1:0] n,
                                                  logic [K_W-1:0] k,
                                                  logic [M_W-1:0] m);
    return {n, 8'd0} + WORD_W'(32'(k) << 6) + WORD_W'(m);
  endfunction

  assign zero_req = (st_q == SRCH_IDLE) && start_i && (freq_i == '0);
  assign go_req   = (st_q == SRCH_IDLE) && start_i && (freq_i != '0);
  assign last_c   = (cur_m_q == M_W'(M_MAX)) && (cur_n_q == N_W'(N_MAX));

  always_comb begin
    if (cur_n_q == N_W'(N_MAX)) begin
      nxt_n = N_W'(N_MIN);
      nxt_m = cur_m_q + M_W'(1);
    end else begin
      nxt_n = cur_n_q + N_W'(1);
      nxt_m = cur_m_q;
    end
  end

  assign ld_m = (st_q == SRCH_IDLE) ? M_W'(M_MIN) : nxt_m;
  assign ld_n = (st_q == SRCH_IDLE) ? N_W'(N_MIN) : nxt_n;
  assign ld_k = (st_q == SRCH_IDLE) ? k_c : k_q;

  // floor(a / (2^s * b)) == floor(floor(a / 2^s) / b): shift first, divide by M+2
  assign prod_c   = 32'(REF_X256) * (32'(ld_n) + 32'd8);
  assign dvd_c    = DVD_W'(prod_c >> (32'd8 + 32'(ld_k)));
  assign dvs_c    = DVS_W'(ld_m) + DVS_W'(2);
  assign div_load = go_req || ((st_q == SRCH_RUN) && div_valid && !last_c);

  pll_quot_div #(
    .DVD_W(DVD_W), .DVS_W(DVS_W), .STEP_BITS(STEP_BITS)
  ) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(div_load),
    .dividend_i(dvd_c), .divisor_i(dvs_c),
    .quot_o(div_q), .valid_o(div_valid)
  );

  assign err_c    = (tgt_q >= 32'(div_q)) ? tgt_q - 32'(div_q) : 32'(div_q) - tgt_q;
  assign better_c = err_c < best_err_q;
  assign fin_m    = better_c ? cur_m_q : best_m_q;
  assign fin_n    = better_c ? cur_n_q : best_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SRCH_IDLE;
      tgt_q      <= '0;
      k_q        <= '0;
      best_err_q <= '1;
      cur_m_q    <= '0;
      cur_n_q    <= '0;
      best_m_q   <= '0;
      best_n_q   <= '0;
      word_o     <= '0;
      m_o        <= '0;
      n_o        <= '0;
      k_o        <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        SRCH_IDLE: begin
          if (zero_req) begin
            word_o <= WORD_W'(ZERO_WORD);
            m_o    <= '0;
            n_o    <= '0;
            k_o    <= '0;
            done_o <= 1'b1;
          end else if (go_req) begin
            st_q       <= SRCH_RUN;
            tgt_q      <= tgt_c;
            k_q        <= k_c;
            best_err_q <= '1;
            cur_m_q    <= M_W'(M_MIN);
            cur_n_q    <= N_W'(N_MIN);
            best_m_q   <= M_W'(M_MIN);
            best_n_q   <= N_W'(N_MIN);
          end
        end
        SRCH_RUN: begin
          if (div_valid) begin
            if (better_c) begin
              best_err_q <= err_c;
              best_m_q   <= cur_m_q;
              best_n_q   <= cur_n_q;
            end
            if (last_c) begin
              word_o <= pack_word(fin_n, k_q, fin_m);
              m_o    <= fin_m;
              n_o    <= fin_n;
              k_o    <= k_q;
              done_o <= 1'b1;
              st_q   <= SRCH_IDLE;
            end else begin
              cur_m_q <= nxt_m;
              cur_n_q <= nxt_n;
            end
          end
        end
        default: st_q <= SRCH_IDLE;
      endcase
    end
  end

  assert_zero_word_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_req |=> (done_o && word_o == WORD_W'(ZERO_WORD) && m_o == '0 && n_o == '0 && k_o == '0));

  assert_pair_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SRCH_RUN) |-> (cur_m_q >= M_W'(M_MIN) && cur_m_q <= M_W'(M_MAX) &&
                            cur_n_q >= N_W'(N_MIN) && cur_n_q <= N_W'(N_MAX)));

  assert_best_mono_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SRCH_RUN) |=> (best_err_q <= $past(best_err_q)));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !zero_req) |=> !done_o);

  assert_hold_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(word_o));

  assert_ignore_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SRCH_RUN && start_i) |=> ($stable(tgt_q) && $stable(k_q)));
endmodule

// File: tb/pll_div_search_test.sv
`timescale 1ns/1ps
module pll_div_search_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] freq = '0;
  logic [15:0] word;
  logic [4:0]  m;
  logic [7:0]  n;
  logic [1:0]  k;
  logic        done;

  int errs = 0;
  int checks = 0;

  localparam int NVEC = 4;
  localparam int unsigned VEC_FREQ [NVEC] = '{5000, 10000, 12345, 20000};
  localparam int unsigned VEC_K    [NVEC] = '{3, 3, 3, 3};
  localparam int LAT = 3 * 29 * 213;

  always #2.5 clk = ~clk;

  pll_div_search uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .freq_i(freq),
    .word_o(word), .m_o(m), .n_o(n), .k_o(k), .done_o(done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic model(input longint f, output longint em, output longint en,
                       output longint ek, output longint ew);
    longint fc, tgt, s, best, fo, d;
    fc = (f < 8000) ? 8000 : ((f > 15938) ? 15938 : f);
    tgt = (fc * 256) / 100;
    ek = 0; s = fc;
    while (s < 64000) begin s = s * 2; ek++; end
    best = 64'hFFFFFFFF; em = 0; en = 0;
    for (longint mm = 2; mm <= 30; mm++) begin
      for (longint nn = 35; nn <= 247; nn++) begin
        fo = (938356 * (nn + 8)) / ((longint'(1) << ek) * 256 * (mm + 2));
        d = (tgt > fo) ? tgt - fo : fo - tgt;
        if (d < best) begin best = d; em = mm; en = nn; end
      end
    end
    ew = (ek << 6) + em + (en << 8);
  endtask

  task automatic run(input logic [15:0] f, output int cyc);
    @(negedge clk); start = 1'b1; freq = f;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done) begin @(negedge clk); cyc++; end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R7: watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int cyc;
    longint em, en, ek, ew;
    logic [15:0] held;

    repeat (3) @(negedge clk);
    chk("R8 reset word", word, 0);
    chk("R8 reset m", m, 0);
    chk("R8 reset n", n, 0);
    chk("R8 reset k", k, 0);
    chk("R8 reset done", done, 0);
    rst_n = 1'b1;

    // R1: zero request, no search
    run(16'd0, cyc);
    chk("R1 latency", cyc, 0);
    chk("R1 word", word, 32'h00E0);
    chk("R1 m", m, 0);
    chk("R1 n", n, 0);
    chk("R1 k", k, 0);
    @(negedge clk);
    chk("R8 done falls", done, 0);

    for (int i = 0; i < NVEC; i++) begin
      model(VEC_FREQ[i], em, en, ek, ew);
      run(VEC_FREQ[i][15:0], cyc);
      if (VEC_FREQ[i] < 8000 || VEC_FREQ[i] > 15938)
        chk("R2 clamped word", word, ew);
      chk("R5 m", m, em);
      chk("R5 n", n, en);
      chk("R3 k", k, VEC_K[i]);
      chk("R3 k model", k, ek);
      chk("R6 word", word, ew);
      chk("R6 packing", word, (longint'(n) << 8) + (longint'(k) << 6) + m);
      chk("R4 range", (m >= 2 && m <= 30 && n >= 35 && n <= 247) ? 1 : 0, 1);
      chk("R7 latency", cyc, LAT);
      held = word;
      @(negedge clk);
      chk("R8 done pulse", done, 0);
      repeat (4) @(negedge clk);
      chk("R8 hold", word, held);
    end

    // R9: start during search is ignored; R10: start in done cycle accepted
    model(9000, em, en, ek, ew);
    @(negedge clk); start = 1'b1; freq = 16'd9000;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done) begin
      @(negedge clk); cyc++;
      if (cyc == 100) begin start = 1'b1; freq = 16'd14000; end
      if (cyc == 101) start = 1'b0;
    end
    chk("R9 word", word, ew);
    chk("R9 latency", cyc, LAT);
    start = 1'b1; freq = 16'd0;
    @(negedge clk); start = 1'b0;
    chk("R10 done again", done, 1);
    chk("R10 word", word, 32'h00E0);
    @(negedge clk);
    chk("R8 done pulse after R10", done, 0);
    chk("R8 hold after R10", word, 32'h00E0);

    summary();
    $finish;
  end
endmodule